// File: doc/BRIEF.md
# Timer capture/compare channel

This block is a 16-bit up-counter paired with a single 16-bit register. A control bit makes the register either a compare value or a capture register. In compare mode, the block raises a one-cycle interrupt pulse when the counter advances onto the stored value. In capture mode, the block copies the counter into the register when a chosen edge arrives on one of two asynchronous timer input pins.

The counter advances by one on each clock where the count enable is high. The count mode selects one of three behaviours:

- the counter runs freely and wraps at the top of its range;
- the counter returns to zero after it reaches the compare value, so that value sets the interval length;
- the counter returns to zero on the valid edge of input 0.

Each input pin has its own two-bit edge-select field. For input 0, the edge that captures is the opposite of the edge that clears. Selecting both edges on input 0 clears on either edge and never captures. Input 1 captures directly on the edge it selects.

Both pins pass through a two-flop synchronizer and then an edge detector. A pin change that is set up before clock edge k takes effect at edge k+2.

Top module: `tmr_capcmp_chan`

## Requirements
- R1: Synchronous reset sets the count, the register value, the control byte and the interrupt output to zero.
- R2: The count rises by one on each clock where cnt_en is high and no clear applies, and wraps from FFFFh to 0000h. Otherwise it holds.
- R3: In compare mode (control bit 0 = 0), match_irq is high for exactly one cycle, the cycle in which the counter has just advanced onto the register value. Capture mode never raises it.
- R4: With count mode 01 (control bits 7:6) in compare mode, the enabled count after the counter reaches the register value loads zero. With value V, the count therefore cycles 0..V and an interrupt occurs every V+1 enabled cycles.
- R5: In free-running mode with a register value of 0000h, exactly one interrupt occurs per 65536 enabled counts, at the wrap from FFFFh to 0000h.
- R6: With count mode 10, the valid edge of input 0 clears the count to zero whether or not cnt_en is high. The edge select for input 0 sits in control bits 3:2: 00 = falling, 01 = rising, 11 = both. The non-valid edge leaves the count alone.
- R7: In capture mode with source 0 (control bit 1 = 0), input 0 captures the count on the rising edge for code 00 and on the falling edge for code 01. Code 11 never captures.
- R8: In capture mode with source 1 (control bit 1 = 1), input 1 captures on the edge given by control bits 5:4: 00 = falling, 01 = rising, 11 = both.
- R9: Edge-select code 10 on either input behaves as if no edge occurred. It neither captures nor clears.
- R10: A write with wr_sel = 0 loads the register only in compare mode and is ignored in capture mode. A write with wr_sel = 1 loads the control byte. rd_sel = 1 reads the control byte back zero-extended; rd_sel = 0 reads the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Count enable |
| tin0_pin | input | 1 | Asynchronous timer input 0 |
| tin1_pin | input | 1 | Asynchronous timer input 1 |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 1 | Write target: 0 = register value, 1 = control byte |
| wr_data | input | 16 | Write data |
| rd_sel | input | 1 | Read source: 0 = register value, 1 = control byte |
| rd_data | output | 16 | Read data |
| count | output | 16 | Current counter value |
| match_irq | output | 1 | One-cycle compare-match interrupt |

## Verification
The hardest case to reach from the ports is the interrupt for a zero compare value in free-running mode. The counter cannot be preloaded, so the bench holds the count enable high for a full 65536-cycle sweep. It then checks that exactly one pulse appears and that it falls on the wrap.

The edge-select decoding is walked with a table. For each entry, the bench parks the pin at the starting level while still in compare mode, so that the edge caused by parking cannot capture. It then switches to capture mode and applies the single edge under test.

// File: rtl/tmr_cc_pkg.sv
package tmr_cc_pkg;

    localparam int CNT_W  = 16;
    localparam int NUM_IN = 2;
    localparam int SYNC_N = 2;

    typedef enum logic [1:0] {
        CM_FREE      = 2'b00,
        CM_CLR_MATCH = 2'b01,
        CM_CLR_EDGE0 = 2'b10,
        CM_RSVD      = 2'b11
    } cnt_mode_e;

    typedef enum logic [1:0] {
        ES_FALL = 2'b00,
        ES_RISE = 2'b01,
        ES_BAD  = 2'b10,
        ES_BOTH = 2'b11
    } edge_sel_e;

    // bit 7:6 mode, 5:4 es1, 3:2 es0, 1 source, 0 capture mode
    typedef struct packed {
        cnt_mode_e mode;
        edge_sel_e es1;
        edge_sel_e es0;
        logic      src1;
        logic      cap_mode;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    typedef struct packed {
        logic rise;
        logic fall;
    } edges_t;

    // valid edge per select code; also the capture edge of input 1
    function automatic logic edge_hit(edge_sel_e sel, edges_t e);
        case (sel)
            ES_FALL: return e.fall;
            ES_RISE: return e.rise;
            ES_BOTH: return e.rise | e.fall;
            default: return 1'b0;
        endcase
    endfunction

    // input 0 captures on the edge opposite to its valid edge
    function automatic logic cap0_hit(edge_sel_e sel, edges_t e);
        case (sel)
            ES_FALL: return e.rise;
            ES_RISE: return e.fall;
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/tmr_cc_sync.sv
module tmr_cc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[STAGES-2:0], d};
    end

    assign q = sh[STAGES-1];
endmodule

// File: rtl/tmr_cc_edge.sv
module tmr_cc_edge
    import tmr_cc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   lvl,
    output edges_t edg
);
    logic prev;

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b0;
        else     prev <= lvl;
    end

    assign edg.rise = lvl & ~prev;
    assign edg.fall = ~lvl & prev;
endmodule

// File: rtl/tmr_cc_counter.sv
module tmr_cc_counter
    import tmr_cc_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cnt_en,
    input  logic         edge_clr,
    input  logic         cmp_en,
    input  logic         clr_on_match,
    input  logic [W-1:0] cmp_val,
    output logic [W-1:0] count,
    output logic         match_evt
);
    logic [W-1:0] inc;
    logic         match_clr;

    assign inc       = count + W'(1);
    assign match_clr = clr_on_match && cmp_en && (count == cmp_val);
    // match is reported when the counter advances onto the value
    assign match_evt = cnt_en && cmp_en && !edge_clr && !match_clr && (inc == cmp_val);

    always_ff @(posedge clk) begin
        if (rst)
            count <= '0;
        else if (edge_clr)
            count <= '0;
        else if (cnt_en)
            count <= match_clr ? '0 : inc;
    end
endmodule

// File: rtl/tmr_capcmp_chan.sv
module tmr_capcmp_chan
    import tmr_cc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cnt_en,
    input  logic             tin0_pin,
    input  logic             tin1_pin,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             rd_sel,
    output logic [CNT_W-1:0] rd_data,
    output logic [CNT_W-1:0] count,
    output logic             match_irq
);
    ctrl_t              ctrl_q;
    logic [CNT_W-1:0]   value_q;
    logic [NUM_IN-1:0]  pins;
    logic [NUM_IN-1:0]  lvl;
    edges_t             edg [NUM_IN];
    logic               edge_clr;
    logic               cap_evt;
    logic               match_evt;

    assign pins = {tin1_pin, tin0_pin};

    for (genvar i = 0; i < NUM_IN; i++) begin : g_in
        tmr_cc_sync #(.STAGES(SYNC_N)) u_sync (
            .clk (clk),
            .rst (rst),
            .d   (pins[i]),
            .q   (lvl[i])
        );
        tmr_cc_edge u_edge (
            .clk (clk),
            .rst (rst),
            .lvl (lvl[i]),
            .edg (edg[i])
        );
    end

    assign edge_clr = (ctrl_q.mode == CM_CLR_EDGE0) && edge_hit(ctrl_q.es0, edg[0]);
    assign cap_evt  = ctrl_q.cap_mode &&
                      (ctrl_q.src1 ? edge_hit(ctrl_q.es1, edg[1])
                                   : cap0_hit(ctrl_q.es0, edg[0]));

    tmr_cc_counter #(.W(CNT_W)) u_cnt (
        .clk          (clk),
        .rst          (rst),
        .cnt_en       (cnt_en),
        .edge_clr     (edge_clr),
        .cmp_en       (!ctrl_q.cap_mode),
        .clr_on_match (ctrl_q.mode == CM_CLR_MATCH),
        .cmp_val      (value_q),
        .count        (count),
        .match_evt    (match_evt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q    <= '0;
            value_q   <= '0;
            match_irq <= 1'b0;
        end else begin
            match_irq <= match_evt;
            if (wr_en && wr_sel)
                ctrl_q <= ctrl_t'(wr_data[CTRL_W-1:0]);
            if (cap_evt)
                value_q <= count;
            else if (wr_en && !wr_sel && !ctrl_q.cap_mode)
                value_q <= wr_data;
        end
    end

    assign rd_data = rd_sel ? {{(CNT_W-CTRL_W){1'b0}}, ctrl_q} : value_q;
endmodule

// File: rtl/tmr_cc_chk.sv
module tmr_cc_chk
    import tmr_cc_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             cnt_en,
    input logic [CNT_W-1:0] count,
    input logic             match_irq,
    input logic [CNT_W-1:0] value_q,
    input ctrl_t            ctrl_q,
    input logic             cap_evt,
    input logic             edge_clr
);
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (count == '0 && value_q == '0 && !match_irq && ctrl_q == '0));

    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        (!cnt_en && !edge_clr) |=> count == $past(count));

    a_r3_single_pulse: assert property (@(posedge clk) disable iff (rst)
        match_irq |=> !match_irq);

    a_r3_needs_enable: assert property (@(posedge clk) disable iff (rst)
        match_irq |-> $past(cnt_en));

    a_r6_edge_clears: assert property (@(posedge clk) disable iff (rst)
        edge_clr |=> count == '0);

    a_r7_capture_loads: assert property (@(posedge clk) disable iff (rst)
        cap_evt |=> value_q == $past(count));

    a_r10_capture_read_only: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.cap_mode && !cap_evt) |=> value_q == $past(value_q));
endmodule

bind tmr_capcmp_chan tmr_cc_chk u_chk (.*);

// File: tb/tmr_capcmp_chan_tb.sv
module tmr_capcmp_chan_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cnt_en = 1'b0;
    logic [1:0]  pins = 2'b00;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [15:0] wr_data = '0;
    logic        rd_sel = 1'b0;
    logic [15:0] rd_data;
    logic [15:0] count;
    logic        match_irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    tmr_capcmp_chan u_dut (
        .clk(clk), .rst(rst), .cnt_en(cnt_en),
        .tin0_pin(pins[0]), .tin1_pin(pins[1]),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data),
        .count(count), .match_irq(match_irq)
    );

    // {src, es[1:0], rising edge, capture expected}
    localparam logic [4:0] VEC [14] = '{
        5'b0_00_1_1, 5'b0_00_0_0, 5'b0_01_0_1, 5'b0_01_1_0,
        5'b0_11_1_0, 5'b0_11_0_0, 5'b0_10_1_0,
        5'b1_00_0_1, 5'b1_00_1_0, 5'b1_01_1_1, 5'b1_01_0_0,
        5'b1_11_1_1, 5'b1_11_0_1, 5'b1_10_0_0
    };

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_n(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; cnt_en = 1'b0; pins = 2'b00;
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr(logic sel, logic [15:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic sel, output logic [15:0] d);
        rd_sel = sel; #1; d = rd_data;
    endtask

    task automatic run(int n);
        cnt_en = 1'b1;
        wait_n(n);
        cnt_en = 1'b0;
    endtask

    initial begin
        logic [15:0] v;
        logic [15:0] snap;
        int irqs;
        int first_k;

        // R1 reset
        wait_n(2);
        do_reset();
        chk("R1 count", count, 0);
        chk("R1 irq", match_irq, 0);
        rd(1'b0, v); chk("R1 value", v, 0);
        rd(1'b1, v); chk("R1 ctrl", v, 0);

        // R3 free-run match at value 7
        wr(1'b0, 16'd7);
        irqs = 0; first_k = -1;
        cnt_en = 1'b1;
        for (int k = 1; k <= 10; k++) begin
            @(negedge clk);
            if (match_irq) begin irqs++; if (first_k < 0) first_k = k; end
        end
        cnt_en = 1'b0;
        chk("R3 irq count", irqs, 1);
        chk("R3 irq cycle", first_k, 7);
        chk("R2 count after 10", count, 10);
        wait_n(3);
        chk("R2 hold", count, 10);

        // R3 no interrupt in capture mode
        do_reset();
        wr(1'b0, 16'd3);
        wr(1'b1, 16'h0001);
        irqs = 0;
        cnt_en = 1'b1;
        for (int k = 1; k <= 10; k++) begin
            @(negedge clk);
            if (match_irq) irqs++;
        end
        cnt_en = 1'b0;
        chk("R3 no irq in capture", irqs, 0);

        // R4 clear on match, value 5
        do_reset();
        wr(1'b0, 16'd5);
        wr(1'b1, 16'h0040);
        irqs = 0;
        cnt_en = 1'b1;
        for (int k = 1; k <= 20; k++) begin
            @(negedge clk);
            if (match_irq) irqs++;
            chk("R4 count sequence", count, k % 6);
        end
        cnt_en = 1'b0;
        chk("R4 irq count", irqs, 3);

        // R5 zero compare value, full sweep
        do_reset();
        irqs = 0; first_k = -1;
        cnt_en = 1'b1;
        for (int k = 1; k <= 65536; k++) begin
            @(negedge clk);
            if (match_irq) begin irqs++; first_k = k; end
            if (k == 65535) chk("R2 top of range", count, 16'hFFFF);
        end
        cnt_en = 1'b0;
        chk("R5 irq count", irqs, 1);
        chk("R5 irq at wrap", first_k, 65536);
        chk("R2 wrap to zero", count, 0);

        // R6 clear on input-0 valid edge
        do_reset();
        wr(1'b1, 16'h0084);
        run(10);
        pins[0] = 1'b1; wait_n(4);
        chk("R6 rising clears", count, 0);
        run(3);
        pins[0] = 1'b0; wait_n(4);
        chk("R6 falling ignored", count, 3);
        wr(1'b1, 16'h008C);
        pins[0] = 1'b1; wait_n(4);
        chk("R6 both clears", count, 0);
        wr(1'b1, 16'h0088);
        run(5);
        pins[0] = 1'b0; wait_n(4);
        chk("R9 code 10 no clear", count, 5);

        // R7 R8 R9 edge-select table
        do_reset();
        foreach (VEC[i]) begin
            logic       src;
            logic [1:0] es;
            logic       rise;
            logic       exp_cap;
            string      tag;
            {src, es, rise, exp_cap} = VEC[i];
            tag = (es == 2'b10) ? "R9 capture" : (src ? "R8 capture" : "R7 capture");
            wr(1'b1, 16'h0000);
            wr(1'b0, 16'hBEEF);
            pins[src] = ~rise;
            wait_n(4);
            run(7);
            wr(1'b1, {8'h00, 2'b00, es, es, src, 1'b1});
            snap = count;
            pins[src] = rise;
            wait_n(4);
            rd(1'b0, v);
            chk(tag, v, exp_cap ? {16'h0, snap} : 32'hBEEF);
        end

        // R10 write ignored in capture mode, control readback
        rd(1'b0, snap);
        wr(1'b0, 16'h1234);
        rd(1'b0, v); chk("R10 write ignored", v, snap);
        wr(1'b1, 16'h0000);
        wr(1'b0, 16'h1234);
        rd(1'b0, v); chk("R10 write accepted", v, 16'h1234);
        wr(1'b1, 16'h00A5);
        rd(1'b1, v); chk("R10 ctrl readback", v, 16'h00A5);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule